// File: doc/BRIEF.md
# Periodic Alarm Matcher

This block holds a parameterised number of alarm slots (two by default) and compares each one against the live calendar time. Each slot stores BCD compare values for second, minute, hour, day of week, date and month. It also stores a six-bit enable mask and a repeat bit. The comparison runs only on the cycle in which the 1 Hz update strobe is high. When every enabled field of an armed slot equals the current time, that slot's status flag is set, and it stays set until the host clears it.

A slot in single mode disarms itself once it has fired and stays quiet until the host writes it again. A slot in repeat mode stays armed. Enabling only some fields therefore gives periodic interrupts: second-only fires once a minute, minute plus second fires once an hour, and so on. The interrupt output is the OR of all slot flags.

Top module: `periodic_alarm_matcher`

## Requirements
- R1: After reset every flag and the interrupt output are low and every slot is disarmed with an empty enable mask.
- R2: A pulse on cfg_we_i[k] loads slot k with the cfg_* compare values, the enable mask and the repeat bit, and arms the slot. No flag changes in the cycle that follows.
- R3: On a cycle with tick_i high, an armed slot whose enabled fields all equal the current time sets its flag. The flag is visible on the clock edge that samples the tick.
- R4: Enable mask bit 0 selects seconds, bit 1 minutes, bit 2 hours, bit 3 day of week, bit 4 date and bit 5 month. A field whose bit is clear never prevents a match.
- R5: A slot with an all-zero enable mask never sets its flag.
- R6: Without tick_i high, no flag is set, even when the time matches.
- R7: With the repeat bit at 0 (single mode), a slot that fires is disarmed. Later matching ticks leave its flag low until the slot is written again.
- R8: With the repeat bit at 1, a slot stays armed and sets its flag on every matching tick.
- R9: A flag stays high until clr_i[k] is pulsed. When a clear and a new match arrive in the same cycle, the flag stays set.
- R10: irq_o is high exactly when at least one flag is high.
- R11: Slots are independent. Writing, matching or clearing one slot does not change another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 1 Hz update strobe, one cycle wide |
| now_sec_i | input | 8 | Current seconds, BCD |
| now_min_i | input | 8 | Current minutes, BCD |
| now_hour_i | input | 8 | Current hours, BCD |
| now_dow_i | input | 3 | Current day of week, 0 to 6 |
| now_date_i | input | 8 | Current day of month, BCD |
| now_mon_i | input | 8 | Current month, BCD |
| cfg_we_i | input | NUM_ALARMS | Per-slot write (and arm) strobe |
| cfg_sec_i | input | 8 | Seconds compare value |
| cfg_min_i | input | 8 | Minutes compare value |
| cfg_hour_i | input | 8 | Hours compare value |
| cfg_dow_i | input | 3 | Day-of-week compare value |
| cfg_date_i | input | 8 | Date compare value |
| cfg_mon_i | input | 8 | Month compare value |
| cfg_en_i | input | 6 | Field enable mask |
| cfg_rep_i | input | 1 | 1 = repeat mode, 0 = single mode |
| clr_i | input | NUM_ALARMS | Per-slot flag clear (host read) |
| flag_o | output | NUM_ALARMS | Per-slot alarm flags |
| irq_o | output | 1 | OR of all flags |

## Verification
Two cases are hard to reach from the ports. The first is a full match of a random six-field time, which almost never happens by chance. To get there, the stimulus builds each time field from either a random value or a copy of a configured slot's compare value, with even odds per field. Partial masks then produce frequent repeat firings, and single-mode slots are re-armed often enough to exercise disarming. The second case is a clear that lands on the same cycle as a matching tick. It is forced by directed steps and also occurs in the random phase, where clears are issued independently of ticks.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int BCD_W      = 8;
  localparam int DOW_W      = 3;
  localparam int DOW_IDX    = 3;

  // field index: 0 sec, 1 min, 2 hour, 3 dow, 4 date, 5 mon
  typedef struct packed {
    logic [BCD_W-1:0] mon;
    logic [BCD_W-1:0] date;
    logic [DOW_W-1:0] dow;
    logic [BCD_W-1:0] hour;
    logic [BCD_W-1:0] min;
    logic [BCD_W-1:0] sec;
  } cal_time_t;

  localparam int TIME_W = $bits(cal_time_t);

  function automatic int fld_w(input int idx);
    return (idx == DOW_IDX) ? DOW_W : BCD_W;
  endfunction

  function automatic int fld_lo(input int idx);
    int acc;
    acc = 0;
    for (int j = 0; j < idx; j++) acc += fld_w(j);
    return acc;
  endfunction
endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
(
  input  cal_time_t             now_i,
  input  cal_time_t             ref_i,
  input  logic [NUM_FIELDS-1:0] en_i,
  output logic                  match_o
);
  logic [NUM_FIELDS-1:0] hit;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam int LO = fld_lo(i);
    localparam int W  = fld_w(i);
    assign hit[i] = ~en_i[i] | (now_i[LO +: W] == ref_i[LO +: W]);
  end

  // empty mask must not fire
  assign match_o = (&hit) & (|en_i);
endmodule

// File: rtl/alarm_slot.sv
module alarm_slot
  import alarm_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  cal_time_t             now_i,
  input  logic                  we_i,
  input  cal_time_t             cfg_time_i,
  input  logic [NUM_FIELDS-1:0] cfg_en_i,
  input  logic                  cfg_rep_i,
  input  logic                  clr_i,
  output logic                  flag_o
);
  cal_time_t             ref_q;
  logic [NUM_FIELDS-1:0] en_q;
  logic                  rep_q;
  logic                  armed_q;
  logic                  match;
  logic                  fire;

  alarm_cmp u_cmp (
    .now_i   (now_i),
    .ref_i   (ref_q),
    .en_i    (en_q),
    .match_o (match)
  );

  assign fire = tick_i & armed_q & match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= '0;
      en_q    <= '0;
      rep_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (we_i) begin
      ref_q   <= cfg_time_i;
      en_q    <= cfg_en_i;
      rep_q   <= cfg_rep_i;
      armed_q <= 1'b1;
    end else if (fire && !rep_q) begin
      armed_q <= 1'b0;
    end
  end

  // set beats clear so an event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (fire)   flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/periodic_alarm_matcher.sv
module periodic_alarm_matcher
  import alarm_pkg::*;
#(
  parameter int NUM_ALARMS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [7:0]            now_sec_i,
  input  logic [7:0]            now_min_i,
  input  logic [7:0]            now_hour_i,
  input  logic [2:0]            now_dow_i,
  input  logic [7:0]            now_date_i,
  input  logic [7:0]            now_mon_i,
  input  logic [NUM_ALARMS-1:0] cfg_we_i,
  input  logic [7:0]            cfg_sec_i,
  input  logic [7:0]            cfg_min_i,
  input  logic [7:0]            cfg_hour_i,
  input  logic [2:0]            cfg_dow_i,
  input  logic [7:0]            cfg_date_i,
  input  logic [7:0]            cfg_mon_i,
  input  logic [5:0]            cfg_en_i,
  input  logic                  cfg_rep_i,
  input  logic [NUM_ALARMS-1:0] clr_i,
  output logic [NUM_ALARMS-1:0] flag_o,
  output logic                  irq_o
);
  cal_time_t now_t, cfg_t;

  assign now_t = '{mon: now_mon_i, date: now_date_i, dow: now_dow_i,
                   hour: now_hour_i, min: now_min_i, sec: now_sec_i};
  assign cfg_t = '{mon: cfg_mon_i, date: cfg_date_i, dow: cfg_dow_i,
                   hour: cfg_hour_i, min: cfg_min_i, sec: cfg_sec_i};

  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_slot
    alarm_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .now_i      (now_t),
      .we_i       (cfg_we_i[k]),
      .cfg_time_i (cfg_t),
      .cfg_en_i   (cfg_en_i),
      .cfg_rep_i  (cfg_rep_i),
      .clr_i      (clr_i[k]),
      .flag_o     (flag_o[k])
    );
  end

  assign irq_o = |flag_o;
endmodule

// File: rtl/alarm_matcher_chk.sv
module alarm_matcher_chk #(
  parameter int NUM_ALARMS = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick_i,
  input logic [NUM_ALARMS-1:0] cfg_we_i,
  input logic [NUM_ALARMS-1:0] clr_i,
  input logic [NUM_ALARMS-1:0] flag_o,
  input logic                  irq_o
);
  for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_k
    // R6: flag only rises on a tick
    a_r6_rise_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[k]) |-> $past(tick_i));
    // R9: flag only falls after a clear
    a_r9_fall_needs_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_o[k]) |-> $past(clr_i[k]));
    // R9: without tick or clear the flag holds
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(tick_i) && !$past(clr_i[k])) |-> $stable(flag_o[k]));
    // R2: a write cycle without tick cannot raise the flag
    a_r2_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(cfg_we_i[k]) && !$past(tick_i)) |-> !$rose(flag_o[k]));
  end

  // R10: irq rises only with a tick, falls only with some clear
  a_r10_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick_i));
  a_r10_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(|clr_i));
endmodule

bind periodic_alarm_matcher alarm_matcher_chk #(.NUM_ALARMS(NUM_ALARMS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .cfg_we_i (cfg_we_i),
  .clr_i    (clr_i),
  .flag_o   (flag_o),
  .irq_o    (irq_o)
);

// File: tb/periodic_alarm_matcher_tb_top.sv
module periodic_alarm_matcher_tb_top;
  localparam int NA = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic          tick;
  logic [7:0]    n_sec, n_min, n_hour, n_date, n_mon;
  logic [2:0]    n_dow;
  logic [NA-1:0] we, clr;
  logic [7:0]    c_sec, c_min, c_hour, c_date, c_mon;
  logic [2:0]    c_dow;
  logic [5:0]    c_en;
  logic          c_rep;
  logic [NA-1:0] flag;
  logic          irq;

  periodic_alarm_matcher #(.NUM_ALARMS(NA)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .now_sec_i(n_sec), .now_min_i(n_min), .now_hour_i(n_hour),
    .now_dow_i(n_dow), .now_date_i(n_date), .now_mon_i(n_mon),
    .cfg_we_i(we), .cfg_sec_i(c_sec), .cfg_min_i(c_min), .cfg_hour_i(c_hour),
    .cfg_dow_i(c_dow), .cfg_date_i(c_date), .cfg_mon_i(c_mon),
    .cfg_en_i(c_en), .cfg_rep_i(c_rep), .clr_i(clr),
    .flag_o(flag), .irq_o(irq)
  );

  // reference model
  logic [7:0] m_sec [NA], m_min [NA], m_hour [NA], m_date [NA], m_mon [NA];
  logic [2:0] m_dow [NA];
  logic [5:0] m_en [NA];
  logic       m_rep [NA], m_arm [NA];
  logic [NA-1:0] m_flag;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  function automatic bit ref_match(input int k);
    if (m_en[k] == 6'd0) return 0;
    if (m_en[k][0] && n_sec  != m_sec[k])  return 0;
    if (m_en[k][1] && n_min  != m_min[k])  return 0;
    if (m_en[k][2] && n_hour != m_hour[k]) return 0;
    if (m_en[k][3] && n_dow  != m_dow[k])  return 0;
    if (m_en[k][4] && n_date != m_date[k]) return 0;
    if (m_en[k][5] && n_mon  != m_mon[k])  return 0;
    return 1;
  endfunction

  task automatic check(input string req);
    n_tests++;
    if (flag !== m_flag || irq !== (|m_flag)) begin
      n_fail++;
      $display("FAIL %s: flag=%b irq=%b expected flag=%b irq=%b",
               req, flag, irq, m_flag, |m_flag);
    end
  endtask

  // called at a negedge with inputs driven; advances one cycle and checks
  task automatic step(input string req);
    logic [NA-1:0] nf;
    nf = m_flag;
    for (int k = 0; k < NA; k++) begin
      bit fire;
      fire = tick && m_arm[k] && ref_match(k);
      if (fire) nf[k] = 1'b1;
      else if (clr[k]) nf[k] = 1'b0;
      if (we[k]) begin
        m_sec[k] = c_sec; m_min[k] = c_min; m_hour[k] = c_hour;
        m_dow[k] = c_dow; m_date[k] = c_date; m_mon[k] = c_mon;
        m_en[k] = c_en; m_rep[k] = c_rep; m_arm[k] = 1'b1;
      end else if (fire && !m_rep[k]) begin
        m_arm[k] = 1'b0;
      end
    end
    m_flag = nf;
    @(negedge clk);
    check(req);
    tick = 0; we = '0; clr = '0;
  endtask

  task automatic set_now(input logic [7:0] s, mi, h, input logic [2:0] d,
                         input logic [7:0] dt, mo);
    n_sec = s; n_min = mi; n_hour = h; n_dow = d; n_date = dt; n_mon = mo;
  endtask

  task automatic set_cfg(input logic [7:0] s, mi, h, input logic [2:0] d,
                         input logic [7:0] dt, mo, input logic [5:0] en,
                         input logic rep);
    c_sec = s; c_min = mi; c_hour = h; c_dow = d; c_date = dt; c_mon = mo;
    c_en = en; c_rep = rep;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tick = 0; we = '0; clr = '0;
    set_now(0, 0, 0, 0, 8'h01, 8'h01);
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < NA; k++) begin
      m_sec[k] = 0; m_min[k] = 0; m_hour[k] = 0; m_dow[k] = 0;
      m_date[k] = 0; m_mon[k] = 0; m_en[k] = 0; m_rep[k] = 0; m_arm[k] = 0;
    end
    m_flag = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 reset");
    // R1: disarmed after reset, tick on matching time does nothing
    tick = 1; step("R1 idle tick");

    // R2: slot 0, single mode, sec=30 min=15
    set_cfg(8'h30, 8'h15, 8'h99, 3'd6, 8'h31, 8'h12, 6'b000011, 1'b0);
    we = 2'b01; step("R2 load");
    set_now(8'h30, 8'h15, 8'h08, 3'd2, 8'h07, 8'h04);
    step("R6 no tick");
    tick = 1; step("R3 match");
    tick = 1; step("R3 hold while set");
    clr = 2'b01; step("R9 clear");
    tick = 1; step("R7 disarmed");
    tick = 1; step("R7 still disarmed");

    // R8/R4: slot 1 repeat, seconds only
    set_cfg(8'h05, 8'h44, 8'h23, 3'd1, 8'h02, 8'h03, 6'b000001, 1'b1);
    we = 2'b10; step("R2 load slot1");
    set_now(8'h05, 8'h10, 8'h01, 3'd4, 8'h20, 8'h09);
    tick = 1; step("R4 partial");
    clr = 2'b10; step("R9 clear slot1");
    set_now(8'h05, 8'h11, 8'h02, 3'd5, 8'h21, 8'h10);
    tick = 1; step("R8 repeat");
    clr = 2'b10; tick = 1; step("R9 clear vs set");
    set_now(8'h06, 8'h11, 8'h02, 3'd5, 8'h21, 8'h10);
    clr = 2'b10; tick = 1; step("R9 clear no match");

    // R5: empty mask
    set_cfg(8'h06, 8'h11, 8'h02, 3'd5, 8'h21, 8'h10, 6'b000000, 1'b1);
    we = 2'b01; step("R5 load");
    tick = 1; step("R5 empty mask");

    // R11: slot 0 all fields, slot 1 untouched
    set_cfg(8'h06, 8'h11, 8'h02, 3'd5, 8'h21, 8'h10, 6'b111111, 1'b0);
    we = 2'b01; step("R11 load");
    tick = 1; step("R11 slot0 only");
    set_now(8'h06, 8'h11, 8'h02, 3'd4, 8'h21, 8'h10);
    clr = 2'b01; step("R10 clear");
    // R4: dow mismatch blocks when enabled
    we = 2'b01; step("R4 reload");
    tick = 1; step("R4 dow blocks");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int src;
      src = $urandom_range(NA - 1);
      if ($urandom_range(15) == 0) begin
        set_cfg(8'($urandom_range(3)), 8'($urandom_range(3)), 8'($urandom_range(2)),
                3'($urandom_range(6)), 8'($urandom_range(2)), 8'($urandom_range(2)),
                6'($urandom), 1'($urandom));
        we = NA'($urandom);
      end
      n_sec  = $urandom_range(1) ? m_sec[src]  : 8'($urandom_range(3));
      n_min  = $urandom_range(1) ? m_min[src]  : 8'($urandom_range(3));
      n_hour = $urandom_range(1) ? m_hour[src] : 8'($urandom_range(2));
      n_dow  = $urandom_range(1) ? m_dow[src]  : 3'($urandom_range(6));
      n_date = $urandom_range(1) ? m_date[src] : 8'($urandom_range(2));
      n_mon  = $urandom_range(1) ? m_mon[src]  : 8'($urandom_range(2));
      tick = 1'($urandom);
      if ($urandom_range(7) == 0) clr = NA'($urandom);
      step("R3 R8 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule